// File: doc/BRIEF.md
# Serial Configuration Port with Three Write-Only Registers

This block is the write side of a three-line serial programming port: a select line (`ser_en`, active low during a frame), a data line and a bit clock. A host pulls the select low, presents sixteen bits most significant first, and strobes each bit in on a rising edge of the bit clock. When the select returns high, the block commits the frame. The two bits received last are the register address. The fourteen bits received before them are the register contents. The three registers hold synthesizer and front-end configuration, a channel divide value, and test-multiplexer selects. Their fields are driven out as parallel signals, and nothing can be read back.

The serial lines are asynchronous to the block's system clock. Each line passes through a synchronizer, and the edges are detected in the system clock domain, so the bit clock must stay at each level for at least a few system clock periods. A saturating bit counter tells apart a complete frame from a truncated one. A truncated frame writes nothing and raises a sticky flag. If more than sixteen bits arrive, only the last sixteen count.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset every field output is 0, `ref_div_ratio` is 9 and `short_frame` is 0.
- R2: A frame is sent most significant bit first. Frame bits 1:0 are the address and frame bits 15:2 are the data. Address 0 loads the configuration register, address 1 the channel register and address 2 the test register.
- R3: Bit-clock edges and data values that occur while `ser_en` is high are not shifted in and do not change any output.
- R4: Outputs keep their values while a frame is being shifted in. The addressed register is loaded only on the rising edge of `ser_en`.
- R5: Configuration register field positions, counted in frame bits: 2 `cp_polarity`, 3 `ref_sel`, 4 `aout_mode`, 6 `cw_test`, 7 `pwr_ctl`, 8 `tx_mode`, 10 `lv_lockout`, 11 `rssi_clip_off`.
- R6: `chan_div` equals frame bits 13:2 of the last frame sent to address 1.
- R7: `atest_sel` equals frame bits 4:2 and `dtest_sel` equals frame bits 7:5 of the last frame sent to address 2.
- R8: `ref_div_ratio` is 9 when `ref_sel` is 0 and 18 when `ref_sel` is 1.
- R9: When more than 16 bits are clocked in during one low period of `ser_en`, the last 16 form the frame.
- R10: If fewer than 16 bits arrive before `ser_en` rises, no register changes and `short_frame` goes to 1 and stays at 1 until reset.
- R11: A complete frame with address 3 changes no register and does not set `short_frame`.
- R12: A write to one register leaves the other two registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en | input | 1 | Frame select, low while bits are sent |
| ser_dat | input | 1 | Serial data |
| ser_clk | input | 1 | Serial bit clock, sampled on rising edge |
| cp_polarity | output | 1 | Charge-pump polarity |
| ref_sel | output | 1 | Reference select |
| aout_mode | output | 1 | Analog output mode |
| cw_test | output | 1 | Continuous-wave test enable |
| pwr_ctl | output | 1 | Transmit power control |
| tx_mode | output | 1 | Transmit mode |
| lv_lockout | output | 1 | Low-voltage lockout |
| rssi_clip_off | output | 1 | Signal-strength clip disable |
| ref_div_ratio | output | 5 | Reference divider ratio, 9 or 18 |
| chan_div | output | 12 | Channel divide value |
| atest_sel | output | 3 | Analog test select |
| dtest_sel | output | 3 | Digital test select |
| short_frame | output | 1 | Sticky truncated-frame flag |

## Verification
A level change on a serial line reaches the edge detectors after two synchronizer flops. The register write follows on the third system clock rising edge after that change. Shifted bits follow the same path, so a rising edge of `ser_en` is reflected on the outputs three edges after it is driven. The bench holds every serial level for four system clocks, which keeps each edge separate from the next. Results are checked on a falling clock edge eight cycles after the select rises, well past that latency. The mid-frame check is taken while the select is still low, at a point where no commit can be pending.

// File: rtl/s3w_pkg.sv
package s3w_pkg;
  localparam int unsigned S3W_DATA_W   = 14;
  localparam int unsigned S3W_ADDR_W   = 2;
  localparam int unsigned S3W_NUM_REGS = 3;
  localparam int unsigned S3W_SYNC_STG = 2;
  localparam int unsigned S3W_REF_BASE = 9;

  typedef enum logic [1:0] {
    RA_CFG  = 2'd0,
    RA_CHAN = 2'd1,
    RA_TEST = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

  // Position of each line inside the synchronizer vector
  localparam int unsigned LN_DAT = 0;
  localparam int unsigned LN_CLK = 1;
  localparam int unsigned LN_EN  = 2;
endpackage

// File: rtl/s3w_rst_sync.sv
module s3w_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/s3w_sync.sv
module s3w_sync #(
  parameter int unsigned     N       = 3,
  parameter int unsigned     STAGES  = 2,
  parameter logic [N-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar b = 0; b < N; b++) begin : g_line
    logic [STAGES-1:0] stg_q;
    logic [STAGES-1:0] stg_d;

    always_comb begin
      stg_d = {stg_q[STAGES-2:0], d[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= {STAGES{RST_VAL[b]}};
      else        stg_q <= stg_d;
    end

    assign q[b] = stg_q[STAGES-1];
  end
endmodule

// File: rtl/s3w_shifter.sv
module s3w_shifter #(
  parameter int unsigned FRAME_W = 16,
  localparam int unsigned CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_s,
  input  logic               clk_s,
  input  logic               dat_s,
  output logic [FRAME_W-1:0] frame,
  output logic               full,
  output logic               commit
);
  logic               en_q, clk_q;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               en_rise, en_fall, take;

  assign en_rise = en_s & ~en_q;
  assign en_fall = ~en_s & en_q;
  assign take    = clk_s & ~clk_q & ~en_s;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (en_fall) cnt_d = '0;
    if (take) begin
      sh_d = {sh_q[FRAME_W-2:0], dat_s};
      if (en_fall)                        cnt_d = CNT_W'(1);
      else if (cnt_q != CNT_W'(FRAME_W))  cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b1;
      clk_q <= 1'b0;
    end else begin
      en_q  <= en_s;
      clk_q <= clk_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sh_q <= '0;
    else if (take) sh_q <= sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (take || en_fall) cnt_q <= cnt_d;
  end

  assign frame  = sh_q;
  assign full   = (cnt_q == CNT_W'(FRAME_W));
  assign commit = en_rise;
endmodule

// File: rtl/s3w_regbank.sv
module s3w_regbank #(
  parameter int unsigned DATA_W   = 14,
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned NUM_REGS = 3,
  localparam int unsigned FRAME_W = DATA_W + ADDR_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             commit,
  input  logic                             full,
  input  logic [FRAME_W-1:0]               frame,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs,
  output logic [NUM_REGS-1:0]              wr_sel,
  output logic                             short_flag
);
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic              short_q, short_d;

  assign addr  = frame[ADDR_W-1:0];
  assign wdata = frame[FRAME_W-1:ADDR_W];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic [DATA_W-1:0] val_q;
    assign wr_sel[k] = commit & full & (addr == ADDR_W'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         val_q <= '0;
      else if (wr_sel[k]) val_q <= wdata;
    end

    assign regs[k] = val_q;
  end

  always_comb begin
    short_d = short_q | (commit & ~full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) short_q <= 1'b0;
    else        short_q <= short_d;
  end

  assign short_flag = short_q;
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import s3w_pkg::*;
#(
  parameter int unsigned DATA_W   = S3W_DATA_W,
  parameter int unsigned ADDR_W   = S3W_ADDR_W,
  parameter int unsigned SYNC_STG = S3W_SYNC_STG,
  parameter int unsigned REF_BASE = S3W_REF_BASE,
  parameter int unsigned CHAN_W   = 12,
  parameter int unsigned TSEL_W   = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 ser_en,
  input  logic                                 ser_dat,
  input  logic                                 ser_clk,
  output logic                                 cp_polarity,
  output logic                                 ref_sel,
  output logic                                 aout_mode,
  output logic                                 cw_test,
  output logic                                 pwr_ctl,
  output logic                                 tx_mode,
  output logic                                 lv_lockout,
  output logic                                 rssi_clip_off,
  output logic [$clog2(2*REF_BASE+1)-1:0]      ref_div_ratio,
  output logic [CHAN_W-1:0]                    chan_div,
  output logic [TSEL_W-1:0]                    atest_sel,
  output logic [TSEL_W-1:0]                    dtest_sel,
  output logic                                 short_frame
);
  localparam int unsigned FRAME_W  = DATA_W + ADDR_W;
  localparam int unsigned NUM_REGS = S3W_NUM_REGS;
  localparam int unsigned RATIO_W  = $clog2(2*REF_BASE+1);

  logic                            rst_i_n;
  logic [2:0]                      lines_raw, lines_s;
  logic [FRAME_W-1:0]              frame;
  logic                            full, commit;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [NUM_REGS-1:0]             wr_sel;
  logic [DATA_W-1:0]               cfg_r, chan_r, test_r;

  s3w_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  always_comb begin
    lines_raw         = '0;
    lines_raw[LN_DAT] = ser_dat;
    lines_raw[LN_CLK] = ser_clk;
    lines_raw[LN_EN]  = ser_en;
  end

  s3w_sync #(.N(3), .STAGES(SYNC_STG), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .d(lines_raw), .q(lines_s)
  );

  s3w_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_i_n),
    .en_s(lines_s[LN_EN]), .clk_s(lines_s[LN_CLK]), .dat_s(lines_s[LN_DAT]),
    .frame(frame), .full(full), .commit(commit)
  );

  s3w_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_i_n), .commit(commit), .full(full), .frame(frame),
    .regs(regs), .wr_sel(wr_sel), .short_flag(short_frame)
  );

  assign cfg_r  = regs[RA_CFG];
  assign chan_r = regs[RA_CHAN];
  assign test_r = regs[RA_TEST];

  // Field positions are data-field bits (frame bit minus ADDR_W)
  assign cp_polarity   = cfg_r[0];
  assign ref_sel       = cfg_r[1];
  assign aout_mode     = cfg_r[2];
  assign cw_test       = cfg_r[4];
  assign pwr_ctl       = cfg_r[5];
  assign tx_mode       = cfg_r[6];
  assign lv_lockout    = cfg_r[8];
  assign rssi_clip_off = cfg_r[9];
  assign ref_div_ratio = cfg_r[1] ? RATIO_W'(2*REF_BASE) : RATIO_W'(REF_BASE);

  assign chan_div  = chan_r[CHAN_W-1:0];
  assign atest_sel = test_r[TSEL_W-1:0];
  assign dtest_sel = test_r[2*TSEL_W-1:TSEL_W];

  // Reserved bits are stored but drive nothing
  logic unused_reserved;
  assign unused_reserved = ^{cfg_r[13:10], cfg_r[7], cfg_r[3],
                             chan_r[DATA_W-1:CHAN_W], test_r[DATA_W-1:2*TSEL_W]};
endmodule

// File: rtl/s3w_checker.sv
module s3w_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        ser_en,
  input logic        commit,
  input logic        full,
  input logic [15:0] frame,
  input logic [2:0]  wr_sel,
  input logic [11:0] chan_div,
  input logic [2:0]  atest_sel,
  input logic        cw_test,
  input logic        short_frame
);
  AST_WRITE_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_sel) |-> (commit && full)); // R10

  AST_SHORT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !full) |=> short_frame); // R10

  AST_SHORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    short_frame |=> short_frame); // R10

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel)); // R12

  AST_ADDR3_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && frame[1:0] == 2'd3) |-> (wr_sel == 3'b000)); // R11

  AST_CHAN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel[1] |=> (chan_div == $past(frame[13:2]))); // R6

  AST_TEST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel[2] |=> (atest_sel == $past(frame[4:2]))); // R7

  AST_HOLD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_en && !$past(ser_en) && !$past(ser_en, 2) && !$past(ser_en, 3) && !$past(ser_en, 4))
    |-> ($stable(chan_div) && $stable(atest_sel) && $stable(cw_test))); // R4
endmodule

bind serial_cfg_port s3w_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .commit(commit), .full(full),
  .frame(frame), .wr_sel(wr_sel), .chan_div(chan_div), .atest_sel(atest_sel),
  .cw_test(cw_test), .short_frame(short_frame)
);

// File: tb/serial_cfg_port_tb.sv
`timescale 1ns/1ps
module serial_cfg_port_tb;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst_n, ser_en, ser_dat, ser_clk;
  logic cp_polarity, ref_sel, aout_mode, cw_test, pwr_ctl, tx_mode, lv_lockout, rssi_clip_off;
  logic [4:0]  ref_div_ratio;
  logic [11:0] chan_div;
  logic [2:0]  atest_sel, dtest_sel;
  logic        short_frame;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [13:0] m_reg [3];
  bit          m_short;

  always #5 clk = ~clk;

  serial_cfg_port u_dut (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_dat(ser_dat), .ser_clk(ser_clk),
    .cp_polarity(cp_polarity), .ref_sel(ref_sel), .aout_mode(aout_mode), .cw_test(cw_test),
    .pwr_ctl(pwr_ctl), .tx_mode(tx_mode), .lv_lockout(lv_lockout), .rssi_clip_off(rssi_clip_off),
    .ref_div_ratio(ref_div_ratio), .chan_div(chan_div), .atest_sel(atest_sel),
    .dtest_sel(dtest_sel), .short_frame(short_frame)
  );

  function automatic logic [7:0] exp_cfg(input logic [13:0] r);
    return {r[9], r[8], r[6], r[5], r[4], r[2], r[1], r[0]};
  endfunction

  function automatic logic [4:0] exp_ratio(input logic [13:0] r);
    return r[1] ? 5'd18 : 5'd9;
  endfunction

  task automatic cmp(input string req, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s (%s): actual=%0h expected=%0h", req, tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    cmp("R5", tag, 32'({rssi_clip_off, lv_lockout, tx_mode, pwr_ctl, cw_test, aout_mode, ref_sel, cp_polarity}),
        32'(exp_cfg(m_reg[0])));
    cmp("R8", tag, 32'(ref_div_ratio), 32'(exp_ratio(m_reg[0])));
    cmp("R6", tag, 32'(chan_div), 32'(m_reg[1][11:0]));
    cmp("R7", tag, 32'({dtest_sel, atest_sel}), 32'(m_reg[2][5:0]));
    cmp("R10", tag, 32'(short_frame), 32'(m_short));
  endtask

  task automatic hold();
    repeat (HOLD) @(negedge clk);
  endtask

  // Sends bits[n-1] first; optionally checks outputs half way through (R4)
  task automatic send_frame(input logic [31:0] bits, input int n, input bit mid_chk);
    ser_en = 1'b0;
    hold();
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = bits[i];
      hold();
      ser_clk = 1'b1;
      hold();
      ser_clk = 1'b0;
      if (mid_chk && i == n / 2) check_all("R4 mid-frame");
    end
    hold();
    ser_en = 1'b1;
    repeat (8) @(negedge clk);
    if (n < 16) m_short = 1'b1;
    else if (bits[1:0] != 2'd3) m_reg[bits[1:0]] = bits[15:2];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; ser_en = 1'b1; ser_dat = 1'b0; ser_clk = 1'b0;
    for (int k = 0; k < 3; k++) m_reg[k] = '0;
    m_short = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_all("R1 reset");

    // R2/R5/R8: all-ones configuration
    send_frame({16'h0, 14'h3FFF, 2'd0}, 16, 1'b0);
    check_all("R2 R5 cfg all ones");
    // R6/R12: channel write must leave configuration intact
    send_frame({16'h0, 2'b00, 12'hA5C, 2'd1}, 16, 1'b1);
    check_all("R6 R12 R4 chan");
    // R7: test selects
    send_frame({16'h0, 6'h00, 3'b101, 3'b011, 2'd2}, 16, 1'b0);
    check_all("R7 test");
    // R8: reference select cleared
    send_frame({16'h0, 14'h3FFD, 2'd0}, 16, 1'b1);
    check_all("R8 ratio 9");

    // R3: toggles with select high are ignored
    for (int t = 0; t < 6; t++) begin
      ser_dat = 1'($urandom);
      hold(); ser_clk = 1'b1; hold(); ser_clk = 1'b0;
    end
    repeat (8) @(negedge clk);
    check_all("R3 idle toggles");
    send_frame({16'h0, 2'b00, 12'h123, 2'd1}, 16, 1'b0);
    check_all("R3 frame after idle toggles");

    // R9: 20 bits, last 16 count
    send_frame({12'h0, 4'hF, 2'b00, 12'h3C7, 2'd1}, 20, 1'b0);
    check_all("R9 long frame");

    // R11: address 3 dropped, flag untouched
    send_frame({16'h0, 14'h2AAA, 2'd3}, 16, 1'b0);
    check_all("R11 addr3");

    // Random complete frames
    for (int r = 0; r < 40; r++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if (w[1:0] == 2'd3) w[1:0] = 2'(r % 3);
      send_frame({16'h0, w}, 16, (r % 5) == 0);
      check_all("R2 random frame");
    end

    // R10: short frame, then a full frame still writes and flag stays set
    send_frame({16'h0, 2'b00, 12'hFFF, 2'd1}, 10, 1'b0);
    check_all("R10 short frame");
    send_frame({16'h0, 2'b00, 12'h0F0, 2'd1}, 16, 1'b0);
    check_all("R10 sticky after good frame");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule